// File: doc/BRIEF.md
# Masked SAD Four-Alignment Unit

This unit compares a four-byte reference word against four overlapping byte windows of an eight-byte source and adds a masked sum of absolute byte differences into four accumulator lanes. The source arrives as a low and a high 32-bit word. Lane k looks at source bytes k through k+3, so one operation scores all four byte alignments of the reference in a single step. This is the kernel of a block-matching motion search.

A reference byte equal to zero acts as a "don't care". It adds nothing to any lane, whatever the source byte under it holds. When a lane's true total goes past the 32-bit range, the `sat_mode` input picks the outcome: clamp to all ones, or wrap modulo 2^32. The arithmetic is combinational. The four results and a valid flag are captured in one register stage on the clock edge that samples `in_valid`.

Top module: `masked_sad_quad`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and every result lane go to zero on that edge.
- R2: `out_valid` is high in the cycle after a rising edge that sampled `in_valid` high, and low after an edge that sampled it low.
- R3: Lane k (result bits 32k+31:32k) is scored against the 32-bit window made of bits 8k+31:8k of {src_hi, src_lo}. Lane 0 therefore uses `src_lo` as it is.
- R4: For byte position i (bits 8i+7:8i), the contribution is the unsigned magnitude |ref byte i − window byte i|. The lane result is the accumulator lane plus the four contributions.
- R5: A reference byte of 0x00 contributes zero to every lane. An all-zero reference returns the accumulator lanes unchanged.
- R6: With `sat_mode` = 0, a lane whose true total exceeds 0xFFFFFFFF outputs that total modulo 2^32.
- R7: With `sat_mode` = 1, a lane whose true total exceeds 0xFFFFFFFF outputs 0xFFFFFFFF. A total of exactly 0xFFFFFFFF is output unchanged.
- R8: After an edge that sampled `in_valid` low, the result lanes keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are present this cycle |
| sat_mode | input | 1 | 1 = clamp on overflow, 0 = wrap |
| ref_word | input | 32 | Four reference bytes |
| src_lo | input | 32 | Source bytes 0..3 |
| src_hi | input | 32 | Source bytes 4..7 |
| acc_in | input | 128 | Four accumulator lanes, lane k at bits 32k+31:32k |
| out_valid | output | 1 | Result lanes were updated by the last edge |
| result | output | 128 | Four result lanes, same lane layout as acc_in |

## Verification
A full sweep of all 256 values of a replicated reference byte against a fixed source with distinct bytes checks the absolute-difference magnitude on both signs of the difference and the zero-byte mask at value 0x00. Distinct bytes in both source words expose any misaligned window, because a wrong byte gives a different sum in each lane. The all-0xFF reference is run against accumulators just below, exactly at and just above the 32-bit limit in both overflow modes, which separates the clamp from the wrap and catches an off-by-one in the overflow test. A stream of pseudo-random operands in both modes, plus idle cycles with changing inputs, covers general mixing and the hold behaviour.

// File: rtl/msad_pkg.sv
package msad_pkg;
  function automatic logic [7:0] byte_absdiff(input logic [7:0] a, input logic [7:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/msad_window.sv
module msad_window #(
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int WW = NB * BW
) (
  input  logic [WW-1:0]    src_lo,
  input  logic [WW-1:0]    src_hi,
  output logic [NB*WW-1:0] windows
);
  for (genvar k = 0; k < NB; k++) begin : g_win
    if (k == 0) begin : g_base
      assign windows[WW-1:0] = src_lo;
    end else begin : g_shift
      assign windows[k*WW +: WW] = {src_hi[k*BW-1:0], src_lo[WW-1:k*BW]};
    end
  end
endmodule

// File: rtl/msad_lane.sv
module msad_lane #(
  parameter int NB = 4,
  parameter int BW = 8,
  parameter int AW = 32,
  localparam int WW = NB * BW,
  localparam int SW = AW + $clog2(NB) + 1
) (
  input  logic [WW-1:0] ref_word,
  input  logic [WW-1:0] win_word,
  input  logic [AW-1:0] acc_lane,
  input  logic          sat_mode,
  output logic [AW-1:0] lane_out
);
  import msad_pkg::*;

  logic [NB*BW-1:0] diffs;
  logic [SW-1:0]    total;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [BW-1:0] r_b, w_b;
    assign r_b = ref_word[i*BW +: BW];
    assign w_b = win_word[i*BW +: BW];
    assign diffs[i*BW +: BW] = (r_b == '0) ? '0 : byte_absdiff(r_b, w_b);
  end

  always_comb begin
    total = SW'(acc_lane);
    for (int i = 0; i < NB; i++) begin
      total = total + SW'(diffs[i*BW +: BW]);
    end
  end

  always_comb begin
    if (sat_mode && (|total[SW-1:AW])) lane_out = '1;
    else                               lane_out = total[AW-1:0];
  end
endmodule

// File: rtl/masked_sad_quad.sv
module masked_sad_quad #(
  parameter int NB = 4,
  parameter int BW = 8,
  parameter int AW = 32,
  localparam int WW = NB * BW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             sat_mode,
  input  logic [WW-1:0]    ref_word,
  input  logic [WW-1:0]    src_lo,
  input  logic [WW-1:0]    src_hi,
  input  logic [NB*AW-1:0] acc_in,
  output logic             out_valid,
  output logic [NB*AW-1:0] result
);
  logic [NB*WW-1:0] windows;
  logic [NB*AW-1:0] lane_sums;

  msad_window #(.NB(NB), .BW(BW)) win_i (
    .src_lo(src_lo), .src_hi(src_hi), .windows(windows)
  );

  for (genvar k = 0; k < NB; k++) begin : g_lane
    msad_lane #(.NB(NB), .BW(BW), .AW(AW)) lane_i (
      .ref_word(ref_word),
      .win_word(windows[k*WW +: WW]),
      .acc_lane(acc_in[k*AW +: AW]),
      .sat_mode(sat_mode),
      .lane_out(lane_sums[k*AW +: AW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= lane_sums;
    end
  end
endmodule

// File: rtl/msad_checker.sv
module msad_checker #(
  parameter int NB = 4,
  parameter int BW = 8,
  parameter int AW = 32,
  localparam int WW = NB * BW
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             sat_mode,
  input logic [WW-1:0]    ref_word,
  input logic [NB*AW-1:0] acc_in,
  input logic             out_valid,
  input logic [NB*AW-1:0] result
);
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  p_zero_ref_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ref_word == '0) |=> result == $past(acc_in));

  for (genvar k = 0; k < NB; k++) begin : g_sat
    p_no_wrap_sat_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && sat_mode) |=> result[k*AW +: AW] >= $past(acc_in[k*AW +: AW]));
  end
endmodule

bind masked_sad_quad msad_checker #(.NB(NB), .BW(BW), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .sat_mode(sat_mode),
  .ref_word(ref_word), .acc_in(acc_in), .out_valid(out_valid), .result(result)
);

// File: tb/masked_sad_quad_tb_top.sv
module masked_sad_quad_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0;
  logic         rst = 1;
  logic         in_valid = 0;
  logic         sat_mode = 0;
  logic [31:0]  ref_word = 0, src_lo = 0, src_hi = 0;
  logic [127:0] acc_in = 0;
  logic         out_valid;
  logic [127:0] result;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  masked_sad_quad dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sat_mode(sat_mode),
    .ref_word(ref_word), .src_lo(src_lo), .src_hi(src_hi), .acc_in(acc_in),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  // behavioural model: returns expected lane and whether it overflowed
  function automatic logic [31:0] model(input int k, input logic [31:0] r,
      input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] a,
      input logic sat, output bit ovf);
    logic [63:0] cat = {hi, lo};
    logic [31:0] w = 32'(cat >> (8*k));
    longint s = longint'(a);
    for (int i = 0; i < 4; i++) begin
      int rb = int'(r[8*i +: 8]);
      int wb = int'(w[8*i +: 8]);
      if (rb != 0) s += (rb >= wb) ? (rb - wb) : (wb - rb);
    end
    ovf = (s > 64'hFFFF_FFFF);
    if (ovf && sat) return 32'hFFFF_FFFF;
    return s[31:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] r, input logic [31:0] lo,
      input logic [31:0] hi, input logic [127:0] a, input logic sat);
    @(negedge clk);
    ref_word = r; src_lo = lo; src_hi = hi; acc_in = a; sat_mode = sat; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check("R2 out_valid", {31'd0, out_valid}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      bit ovf;
      logic [31:0] e = model(k, r, lo, hi, a[32*k +: 32], sat, ovf);
      string t = tag;
      if (ovf) t = sat ? "R7 saturate" : "R6 wrap";
      check(t, result[32*k +: 32], e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", result[31:0] | result[63:32] | result[95:64] | result[127:96], 32'd0);
    rst = 0;

    // R5: all-zero reference returns accumulators
    apply("R5 zero ref", 32'h0, 32'hA1B2_C3D4, 32'hE5F6_0718,
          {32'd4, 32'd3, 32'd2, 32'h8000_0001}, 1'b0);
    // R5: partial masking, FF source under zero ref bytes
    apply("R5 partial mask", 32'h0010_0020, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 128'd0, 1'b0);

    // R4/R5: sweep all byte values against distinct source bytes
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b = 8'(v);
      apply("R4 byte sweep", {b, b, b, b}, 32'h4030_2010, 32'h8070_6050,
            {32'd1000, 32'd200, 32'd30, 32'd4}, v[0]);
    end

    // R3: window alignment, distinct bytes with single nonzero reference byte
    for (int p = 0; p < 4; p++) begin
      apply("R3 window", 32'h0000_0001 << (8*p), 32'h3322_1100, 32'h7766_5544, 128'd0, 1'b0);
    end

    // R6/R7: all-0xFF reference, zero source, accumulators around the limit
    for (int s = 0; s < 2; s++) begin
      apply("R7 edge", 32'hFFFF_FFFF, 32'h0, 32'h0,
            {32'hFFFF_FFFF, 32'hFFFF_FC03, 32'hFFFF_FC04, 32'hFFFF_FC02}, s[0]);
      apply("R6 edge", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,
            {32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'hFFFF_FF00, 32'hFFFF_FFFF}, s[0]);
    end

    // pseudo-random mix, both modes
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r, lo, hi;
      logic [127:0] a;
      seed = nxt(seed); r = seed;
      seed = nxt(seed); lo = seed;
      seed = nxt(seed); hi = seed;
      for (int k = 0; k < 4; k++) begin
        seed = nxt(seed);
        a[32*k +: 32] = n[1] ? (32'hFFFF_FF00 | seed[9:0]) : seed;
      end
      apply("R4 random", r, lo, hi, a, n[0]);
    end

    // R8 and R2: idle cycles with changing inputs hold the result
    held = result;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      ref_word = 32'h0102_0304 + n; src_lo = ~src_lo; acc_in = ~acc_in;
      @(negedge clk);
      check("R2 idle valid", {31'd0, out_valid}, 32'd0);
      check("R8 hold", result[32*n +: 32], held[32*n +: 32]);
    end

    // R1: reset mid-run clears state
    apply("R4 pre-reset", 32'h0505_0505, 32'h0, 32'h0, 128'd7, 1'b0);
    @(negedge clk); rst = 1;
    @(negedge clk);
    check("R1 re-reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 re-reset result", result[31:0], 32'd0);
    rst = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule